// File: doc/BRIEF.md
# EEPROM page write buffer controller

This block is a synthesizable behavioural model of the page-write path of a parallel EEPROM. A host issues single-byte writes on an address, data and write-strobe interface. The first strobe of a sequence latches the page number from the upper address bits. The same strobe copies the page's current contents into a page-wide RAM buffer and merges the new byte into it. Later strobes in the same sequence use only the low offset bits, so they land inside the latched page and wrap around at its end. Incoming bytes stay in the buffer and do not reach the array yet.

When no strobe arrives for `LOAD_TIMEOUT` cycles, the load window closes and an internal commit cycle starts. The commit erases the whole page to ones in one step, then programs all zero bits of the buffered page in one step. `busy` is high for the whole erase and program span. While `busy` is high, host writes are ignored and the asynchronous read port returns the contents last committed. An `abort` input during the commit ends it at once.

The controller has four states. `IDLE` goes to `LOAD` on a strobe. `LOAD` stays in `LOAD` on each strobe, and goes to `ERASE` after a quiet window. `ERASE` goes to `PROGRAM` after `ERASE_CYCLES` cycles. `PROGRAM` goes to `IDLE` after `PROGRAM_CYCLES` cycles. `ERASE` and `PROGRAM` both return to `IDLE` on `abort`.

Top module: `eeprom_page_writer`

## Requirements
- R1: After reset, `busy` is low and every array location reads 8'hFF.
- R2: The first strobe in `IDLE` preloads the buffer with the addressed page's current bytes and merges the written byte. After the commit, the written byte reads back and every other byte of that page keeps its earlier value.
- R3: Within one load window, strobes after the first ignore `wr_addr` bits above bit `PAGE_W-1` and write offset `wr_addr[PAGE_W-1:0]` of the latched page. No other page changes.
- R4: A byte written during the load window is not visible on `rd_data` until the commit has finished.
- R5: `busy` rises exactly `LOAD_TIMEOUT` clock edges after the edge that sampled the last strobe. Each strobe in the window restarts this count.
- R6: `busy` stays high for exactly `ERASE_CYCLES + PROGRAM_CYCLES` cycles. After it falls, the page reads back exactly the buffered bytes, the erase to ones being followed by programming of zeros.
- R7: Strobes while `busy` is high have no effect on the array and start no new load window.
- R8: While `busy` is high, `rd_data` returns the last committed contents of any address, including addresses in the page being committed.
- R9: `abort` sampled high during `ERASE` or `PROGRAM` makes `busy` low on the next cycle. Pages other than the one being committed are not changed.
- R10: When one offset is written more than once in a window, the last byte written is committed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host byte-write strobe, one cycle per byte |
| wr_addr | input | ADDR_W | Write address; upper bits select the page on the first strobe |
| wr_data | input | DATA_W | Write byte |
| abort | input | 1 | Stops a running commit |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Committed contents of `rd_addr`, combinational |
| busy | output | 1 | High during the erase and program phases |

## Verification
The bench builds the block with `ADDR_W=9` and `PAGE_W=7`, which gives four 128-byte pages. This lets page wrap and untouched-neighbour pages be checked across the whole array. `LOAD_TIMEOUT=8`, `ERASE_CYCLES=6` and `PROGRAM_CYCLES=5` keep each commit short. Exact window and busy lengths can then be counted, strobes can be placed inside the window to restart it and inside `busy` to test that they are ignored, and `abort` can be placed in each phase.

// File: rtl/eepw_pkg.sv
package eepw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_LOAD    = 2'd1,
        ST_ERASE   = 2'd2,
        ST_PROGRAM = 2'd3
    } eepw_state_t;

endpackage

// File: rtl/eepw_seq.sv
module eepw_seq
    import eepw_pkg::*;
#(
    parameter int LOAD_TIMEOUT   = 64,
    parameter int ERASE_CYCLES   = 40,
    parameter int PROGRAM_CYCLES = 40
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        abort,
    output eepw_state_t state,
    output logic        open_page,
    output logic        take_byte,
    output logic        erase_go,
    output logic        prog_go,
    output logic        busy
);

    localparam int MAX_AB = (ERASE_CYCLES > PROGRAM_CYCLES) ? ERASE_CYCLES : PROGRAM_CYCLES;
    localparam int MAX_C  = (LOAD_TIMEOUT > MAX_AB) ? LOAD_TIMEOUT : MAX_AB;
    localparam int CNT_W  = $clog2(MAX_C + 1);
    localparam logic [CNT_W-1:0] LOAD_LAST  = CNT_W'(LOAD_TIMEOUT - 1);
    localparam logic [CNT_W-1:0] ERASE_LAST = CNT_W'(ERASE_CYCLES - 1);
    localparam logic [CNT_W-1:0] PROG_LAST  = CNT_W'(PROGRAM_CYCLES - 1);

    eepw_state_t      state_q, state_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;

    // next-state logic
    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (wr_en) begin
                    state_n = ST_LOAD;
                    cnt_n   = '0;
                end
            end
            ST_LOAD: begin
                if (wr_en) begin
                    cnt_n = '0;
                end else if (cnt_q == LOAD_LAST) begin
                    state_n = ST_ERASE;
                    cnt_n   = '0;
                end else begin
                    cnt_n = cnt_q + 1'b1;
                end
            end
            ST_ERASE: begin
                if (abort) begin
                    state_n = ST_IDLE;
                    cnt_n   = '0;
                end else if (cnt_q == ERASE_LAST) begin
                    state_n = ST_PROGRAM;
                    cnt_n   = '0;
                end else begin
                    cnt_n = cnt_q + 1'b1;
                end
            end
            ST_PROGRAM: begin
                if (abort || cnt_q == PROG_LAST) begin
                    state_n = ST_IDLE;
                    cnt_n   = '0;
                end else begin
                    cnt_n = cnt_q + 1'b1;
                end
            end
            default: begin
                state_n = ST_IDLE;
                cnt_n   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
        end
    end

    // outputs
    always_comb begin
        open_page = 1'b0;
        take_byte = 1'b0;
        erase_go  = 1'b0;
        prog_go   = 1'b0;
        busy      = 1'b0;
        unique case (state_q)
            ST_IDLE:    open_page = wr_en;
            ST_LOAD:    take_byte = wr_en;
            ST_ERASE: begin
                busy     = 1'b1;
                erase_go = !abort && (cnt_q == ERASE_LAST);
            end
            ST_PROGRAM: begin
                busy    = 1'b1;
                prog_go = !abort && (cnt_q == PROG_LAST);
            end
            default: ;
        endcase
    end

    assign state = state_q;

    // R5: a strobe inside the window keeps the sequencer loading
    a_r5_strobe_holds_window : assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOAD && wr_en) |=> (state_q == ST_LOAD));

    // R6: a completed erase is always followed by programming
    a_r6_erase_then_program : assert property (@(posedge clk) disable iff (!rst_n)
        erase_go |=> (state_q == ST_PROGRAM));

    // R7: no strobe during commit reopens the load state
    a_r7_busy_no_load : assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !abort && !prog_go) |=> (state_q != ST_LOAD));

endmodule

// File: rtl/eepw_page_buf.sv
module eepw_page_buf #(
    parameter int DATA_W = 8,
    parameter int PAGE_W = 7,
    parameter int PG_W   = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          open_page,
    input  logic                          take_byte,
    input  logic                          busy,
    input  logic [PG_W-1:0]               new_page,
    input  logic [PAGE_W-1:0]             offset,
    input  logic [DATA_W-1:0]             data,
    input  logic [(1<<PAGE_W)*DATA_W-1:0] preload_vec,
    output logic [PG_W-1:0]               page_q,
    output logic [(1<<PAGE_W)*DATA_W-1:0] buf_vec,
    output logic [(1<<PAGE_W)*DATA_W-1:0] snap_vec
);

    localparam int PAGE_BYTES = 1 << PAGE_W;

    logic [DATA_W-1:0] buf_q  [PAGE_BYTES];
    logic [DATA_W-1:0] snap_q [PAGE_BYTES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q <= '0;
            for (int i = 0; i < PAGE_BYTES; i++) begin
                buf_q[i]  <= '1;
                snap_q[i] <= '1;
            end
        end else if (open_page) begin
            page_q <= new_page;
            for (int i = 0; i < PAGE_BYTES; i++) begin
                snap_q[i] <= preload_vec[i*DATA_W +: DATA_W];
                buf_q[i]  <= (offset == PAGE_W'(i)) ? data : preload_vec[i*DATA_W +: DATA_W];
            end
        end else if (take_byte) begin
            buf_q[offset] <= data;
        end
    end

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_pack
        assign buf_vec[g*DATA_W +: DATA_W]  = buf_q[g];
        assign snap_vec[g*DATA_W +: DATA_W] = snap_q[g];
    end

    // R7: the buffer and latched page are frozen during a commit
    a_r7_buf_frozen : assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(buf_vec) && $stable(page_q)));

endmodule

// File: rtl/eepw_array.sv
module eepw_array #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8,
    parameter int PAGE_W = 7
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ADDR_W-PAGE_W-1:0]      sel_page,
    output logic [(1<<PAGE_W)*DATA_W-1:0] page_vec,
    input  logic                          erase_go,
    input  logic                          prog_go,
    input  logic [ADDR_W-PAGE_W-1:0]      tgt_page,
    input  logic [(1<<PAGE_W)*DATA_W-1:0] prog_vec,
    input  logic [ADDR_W-1:0]             rd_addr,
    output logic [DATA_W-1:0]             rd_raw
);

    localparam int PG_W       = ADDR_W - PAGE_W;
    localparam int NUM_PAGES  = 1 << PG_W;
    localparam int PAGE_BYTES = 1 << PAGE_W;

    logic [DATA_W-1:0] mem [NUM_PAGES][PAGE_BYTES];
    logic              row_ones;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int p = 0; p < NUM_PAGES; p++) begin
                for (int i = 0; i < PAGE_BYTES; i++) begin
                    mem[p][i] <= '1;
                end
            end
        end else if (erase_go) begin
            for (int i = 0; i < PAGE_BYTES; i++) begin
                mem[tgt_page][i] <= '1;
            end
        end else if (prog_go) begin
            for (int i = 0; i < PAGE_BYTES; i++) begin
                mem[tgt_page][i] <= mem[tgt_page][i] & prog_vec[i*DATA_W +: DATA_W];
            end
        end
    end

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_row
        assign page_vec[g*DATA_W +: DATA_W] = mem[sel_page][g];
    end

    assign rd_raw = mem[rd_addr[ADDR_W-1:PAGE_W]][rd_addr[PAGE_W-1:0]];

    always_comb begin
        row_ones = 1'b1;
        for (int i = 0; i < PAGE_BYTES; i++) begin
            row_ones = row_ones & (&mem[tgt_page][i]);
        end
    end

    // R6: the erase step leaves every bit of the target page at one
    a_r6_erase_all_ones : assert property (@(posedge clk) disable iff (!rst_n)
        erase_go |=> row_ones);

endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
    import eepw_pkg::*;
#(
    parameter int ADDR_W         = 10,
    parameter int DATA_W         = 8,
    parameter int PAGE_W         = 7,
    parameter int LOAD_TIMEOUT   = 64,
    parameter int ERASE_CYCLES   = 40,
    parameter int PROGRAM_CYCLES = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              abort,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy
);

    localparam int PG_W     = ADDR_W - PAGE_W;
    localparam int VEC_W    = (1 << PAGE_W) * DATA_W;
    localparam int BUSY_LEN = ERASE_CYCLES + PROGRAM_CYCLES;
    localparam int RUN_W    = $clog2(BUSY_LEN + 2);

    eepw_state_t       state;
    logic              open_page, take_byte, erase_go, prog_go;
    logic [PG_W-1:0]   page_q, sel_page;
    logic [VEC_W-1:0]  page_vec, buf_vec, snap_vec;
    logic [DATA_W-1:0] rd_raw;
    logic              hold_old;
    logic [RUN_W-1:0]  busy_run;

    eepw_seq #(
        .LOAD_TIMEOUT  (LOAD_TIMEOUT),
        .ERASE_CYCLES  (ERASE_CYCLES),
        .PROGRAM_CYCLES(PROGRAM_CYCLES)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .abort    (abort),
        .state    (state),
        .open_page(open_page),
        .take_byte(take_byte),
        .erase_go (erase_go),
        .prog_go  (prog_go),
        .busy     (busy)
    );

    assign sel_page = (state == ST_IDLE) ? wr_addr[ADDR_W-1:PAGE_W] : page_q;

    eepw_page_buf #(
        .DATA_W(DATA_W),
        .PAGE_W(PAGE_W),
        .PG_W  (PG_W)
    ) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .open_page  (open_page),
        .take_byte  (take_byte),
        .busy       (busy),
        .new_page   (wr_addr[ADDR_W-1:PAGE_W]),
        .offset     (wr_addr[PAGE_W-1:0]),
        .data       (wr_data),
        .preload_vec(page_vec),
        .page_q     (page_q),
        .buf_vec    (buf_vec),
        .snap_vec   (snap_vec)
    );

    eepw_array #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .PAGE_W(PAGE_W)
    ) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_page(sel_page),
        .page_vec(page_vec),
        .erase_go(erase_go),
        .prog_go (prog_go),
        .tgt_page(page_q),
        .prog_vec(buf_vec),
        .rd_addr (rd_addr),
        .rd_raw  (rd_raw)
    );

    // reads of the page in flight come from the pre-commit snapshot
    assign hold_old = busy && (rd_addr[ADDR_W-1:PAGE_W] == page_q);
    assign rd_data  = hold_old ? snap_vec[rd_addr[PAGE_W-1:0]*DATA_W +: DATA_W] : rd_raw;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    busy_run <= '0;
        else if (busy) busy_run <= busy_run + 1'b1;
        else           busy_run <= '0;
    end

    // R5: a commit only begins after a cycle with no strobe
    a_r5_quiet_before_busy : assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !$past(wr_en));

    // R6: the busy span never exceeds the erase plus program length
    a_r6_busy_len : assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_run < RUN_W'(BUSY_LEN)));

    // R8: committed contents seen at the read port hold still during a commit
    a_r8_read_stable : assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && $stable(rd_addr)) |-> $stable(rd_data));

    // R9: abort ends the commit on the next cycle
    a_r9_abort_drops : assert property (@(posedge clk) disable iff (!rst_n)
        (busy && abort) |=> !busy);

endmodule

// File: tb/test_eeprom_page_writer.sv
module test_eeprom_page_writer;

    localparam int AW = 9;
    localparam int DW = 8;
    localparam int PW = 7;
    localparam int T  = 8;
    localparam int E  = 6;
    localparam int P  = 5;
    localparam int NB = 1 << AW;
    localparam int PB = 1 << PW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          abort = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic          busy;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model state
    int m_mem [NB];
    bit m_known [NB/PB];
    int m_buf [PB];
    int m_page, m_state, m_cnt;

    always #5 clk = ~clk;

    eeprom_page_writer #(
        .ADDR_W(AW), .DATA_W(DW), .PAGE_W(PW),
        .LOAD_TIMEOUT(T), .ERASE_CYCLES(E), .PROGRAM_CYCLES(P)
    ) i_eeprom_page_writer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .abort(abort), .rd_addr(rd_addr),
        .rd_data(rd_data), .busy(busy)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // behavioural model: 0 idle, 1 load, 2 erase, 3 program
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NB; i++) m_mem[i] = 255;
            for (int i = 0; i < NB/PB; i++) m_known[i] = 1'b1;
            m_state = 0;
            m_cnt = 0;
            m_page = 0;
        end else begin
            case (m_state)
                0: if (wr_en) begin
                    m_page = int'(wr_addr) / PB;
                    for (int i = 0; i < PB; i++) m_buf[i] = m_mem[m_page*PB + i];
                    m_buf[int'(wr_addr) % PB] = int'(wr_data);
                    m_state = 1;
                    m_cnt = 0;
                end
                1: if (wr_en) begin
                    m_buf[int'(wr_addr) % PB] = int'(wr_data);
                    m_cnt = 0;
                end else if (m_cnt == T-1) begin
                    m_state = 2;
                    m_cnt = 0;
                end else m_cnt++;
                2: if (abort) begin
                    m_known[m_page] = 1'b0;
                    m_state = 0;
                end else if (m_cnt == E-1) begin
                    m_state = 3;
                    m_cnt = 0;
                end else m_cnt++;
                default: if (abort) begin
                    m_known[m_page] = 1'b0;
                    m_state = 0;
                end else if (m_cnt == P-1) begin
                    for (int i = 0; i < PB; i++) m_mem[m_page*PB + i] = m_buf[i];
                    m_state = 0;
                end else m_cnt++;
            endcase
        end
    end

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            #3;
            chk("R6 busy vs model", busy, (m_state >= 2) ? 1 : 0);
            if (m_known[int'(rd_addr) / PB])
                chk("R8 read vs model", rd_data, m_mem[rd_addr]);
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_addr = AW'(a);
        wr_data = DW'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, input int exp, input string tag);
        @(negedge clk);
        rd_addr = AW'(a);
        #1;
        chk(tag, rd_data, exp);
    endtask

    task automatic wait_done();
        while (!busy) @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy after reset", busy, 0);
        rd(9'h000, 8'hFF, "R1 erased after reset");
        rd(9'h1FF, 8'hFF, "R1 erased after reset");

        // single byte into page 1
        wr(9'h085, 8'h12);
        rd(9'h085, 8'hFF, "R4 byte held in buffer");
        wait_done();
        rd(9'h085, 8'h12, "R2 written byte");
        rd(9'h084, 8'hFF, "R2 neighbour byte");
        wr(9'h086, 8'h34);
        wait_done();
        rd(9'h085, 8'h12, "R2 earlier byte preserved");
        rd(9'h086, 8'h34, "R2 new byte");

        // window and busy lengths
        wr(9'h0C0, 8'h56);
        n = 0;
        while (!busy) begin @(negedge clk); n++; end
        chk("R5 window latency", n, T);
        n = 0;
        while (busy) begin n++; @(negedge clk); end
        chk("R6 busy length", n, E + P);
        rd(9'h0C0, 8'h56, "R6 committed byte");

        // strobe inside the window restarts it
        wr(9'h040, 8'h77);
        repeat (T - 3) @(negedge clk);
        chk("R5 window still open", busy, 0);
        wr(9'h041, 8'h78);
        n = 0;
        while (!busy) begin @(negedge clk); n++; end
        chk("R5 restart latency", n, T);
        while (busy) @(negedge clk);
        rd(9'h040, 8'h77, "R5 first byte");
        rd(9'h041, 8'h78, "R5 second byte");

        // wrap inside the latched page 2
        wr(9'h100, 8'hA0);
        wr(9'h1FF, 8'hB1);
        wr(9'h07E, 8'hC2);
        wait_done();
        rd(9'h17F, 8'hB1, "R3 wrap to latched page");
        rd(9'h17E, 8'hC2, "R3 upper bits ignored");
        rd(9'h1FF, 8'hFF, "R3 other page untouched");
        rd(9'h07E, 8'hFF, "R3 other page untouched");

        // last write wins
        wr(9'h0A0, 8'h11);
        wr(9'h0A0, 8'h22);
        wait_done();
        rd(9'h0A0, 8'h22, "R10 last write wins");

        // reads and writes while busy
        wr(9'h0B0, 8'h5A);
        while (!busy) @(negedge clk);
        rd(9'h0B0, 8'hFF, "R8 old contents during busy");
        rd(9'h085, 8'h12, "R8 same page during busy");
        wr(9'h0B1, 8'h66);
        wr(9'h1B1, 8'h67);
        while (busy) @(negedge clk);
        rd(9'h0B0, 8'h5A, "R6 committed after busy");
        rd(9'h0B1, 8'hFF, "R7 write during busy ignored");
        rd(9'h1B1, 8'hFF, "R7 write during busy ignored");
        repeat (T + 3) @(negedge clk);
        chk("R7 no new cycle", busy, 0);

        // abort in erase
        wr(9'h0F0, 8'h01);
        while (!busy) @(negedge clk);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        chk("R9 abort in erase", busy, 0);

        // abort in program
        wr(9'h1F0, 8'h02);
        while (!busy) @(negedge clk);
        repeat (E) @(negedge clk);
        chk("R9 still busy in program", busy, 1);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        chk("R9 abort in program", busy, 0);
        rd(9'h17F, 8'hB1, "R9 other page kept");
        rd(9'h041, 8'h78, "R9 other page kept");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule